// File: doc/BRIEF.md
# Multi-Queue Linked-List Buffer Pool

The block holds in-flight register writes for six independent consumer queues in one shared store. One producer pushes one 128-bit chunk per cycle and tags it with a queue number. Each consumer drains its own queue through a valid/ready pop port, so the store is written in order but read out of order. Storage is organised as blocks of eight chunks. A queue is a singly linked list of blocks, and the links are kept in a next-block table indexed by block number, separate from the chunk store.

Each queue tracks its write position and its read position as a block number plus a 3-bit chunk offset. Both sides keep two block registers. An offset of 3 or less selects the second register, and a larger offset selects the first. On the read side, the previous block is released when the read offset moves from 3 to 4. The link to the following block is fetched once the writer has moved on, which happens before the read offset wraps. Blocks that no queue holds sit in a free map. A push that must open a new block while the map is empty is held off.

Top module: `mq_block_pool`

## Requirements
- R1: After reset every queue is empty: pop_valid is 0, every q_chunks field is 0, every q_blocks field is 1, and push_ready is 1.
- R2: Each queue returns chunks in the order they were pushed. While pop_valid is 1 and pop_ready is 0, the presented chunk stays unchanged.
- R3: A pop on one queue does not change the head chunk, the validity or the occupancy of any other queue.
- R4: pop_valid of a queue is 1 exactly when its read position differs from its write position. q_chunks equals the number of chunks pushed minus the number popped.
- R5: A push made while the queue's write offset is 7 links a fresh block to the tail, and q_blocks rises by 1. Starting from a fresh queue, this happens on the 8th and 16th pushes, and order is kept across the block boundary.
- R6: A block is released when the read offset passes from 3 to 4 in the block that follows it, and q_blocks falls by 1 at that pop. For 16 pushes into a fresh queue, q_blocks is 3 after 11 pops and 2 after 12 pops.
- R7: At reset queue q holds block q, and the NBLK-NQ other blocks are free. When no block is free, push_ready is 0 only for a push whose target queue has write offset 7. A block released by a pop becomes usable in the cycle after that pop, not in the same cycle.
- R8: pop_keep holds, per queue, {bit 1, bit 0} of the head chunk (slot 1 enable, slot 0 enable) while pop_valid is 1, and 2'b00 otherwise. All other chunk bits are carried unchanged.
- R9: A push with a queue number of NQ or more is accepted (push_ready 1) and dropped: no queue changes.
- R10: A push and a pop on the same queue in the same cycle both take effect, and q_chunks is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Producer offers a chunk |
| push_ready | output | 1 | Chunk is accepted this cycle |
| push_qid | input | $clog2(NQ) | Target queue of the chunk |
| push_chunk | input | 128 | Chunk: two register-write slots, enables in bits 0 and 1 |
| pop_valid | output | NQ | Queue q has a chunk at its head |
| pop_ready | input | NQ | Consumer q takes the head chunk |
| pop_chunk | output | NQ*128 | Head chunk of each queue, queue q at bits q*128 upward |
| pop_keep | output | NQ*2 | Slot enables of each head chunk, zero when empty |
| q_chunks | output | NQ*$clog2(NBLK*8+1) | Chunks held per queue |
| q_blocks | output | NQ*$clog2(NBLK+1) | Blocks held per queue |

## Verification
The two functions that can fall in one cycle are a block release, caused by a pop whose read offset moves from 3 to 4, and a push that needs a new block while the free map is empty. The bench fills one queue until every spare block is taken and its write offset sits at 7. It then drives the releasing pop and a push into that queue in the same cycle. The push must be refused in that cycle and accepted in the next, and q_blocks must go down and then up by one. A push and a pop on the same queue in one cycle are also driven together and judged through the unchanged chunk count and the order of the chunks that follow.

// File: rtl/mqp_pkg.sv
// Shared constants and helpers of the multi-queue block pool.
// Assumes a fixed 128-bit chunk and eight chunks per block.
package mqp_pkg;
    localparam int CHUNK_W = 128;
    localparam int OFF_W   = 3;
    localparam int CPB     = 1 << OFF_W;
    localparam logic [OFF_W-1:0] HALF_LAST = OFF_W'(CPB / 2 - 1);
    localparam logic [OFF_W-1:0] OFF_LAST  = '1;

    // Slot enables of a chunk: bit 1 for slot 1, bit 0 for slot 0.
    function automatic logic [1:0] slot_enables(input logic [CHUNK_W-1:0] c);
        return c[1:0];
    endfunction
endpackage

// File: rtl/pool_free_map.sv
// Free-block map: one bit per block, set while the block is unowned.
// The lowest set bit is offered for allocation. Any number of blocks may
// be returned in one cycle. A returned block can be taken from the next
// cycle on. Assumes the blocks below NQ are handed to the queues at reset.
module pool_free_map #(
    parameter int NBLK = 128,
    parameter int NQ   = 6,
    localparam int BLK_W = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [NQ-1:0]    rel_en,
    input  logic [BLK_W-1:0] rel_id [NQ],
    output logic             avail,
    output logic [BLK_W-1:0] pick
);
    logic [NBLK-1:0] map;
    logic [NBLK-1:0] give_back;
    logic [NBLK-1:0] taken;

    // Lowest free block index.
    always_comb begin
        pick = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (map[i]) pick = BLK_W'(i);
        end
    end

    // Mask of blocks returned by the readers this cycle.
    always_comb begin
        give_back = '0;
        for (int q = 0; q < NQ; q++) begin
            if (rel_en[q]) give_back[rel_id[q]] = 1'b1;
        end
    end

    // Mask of the block allocated this cycle.
    always_comb begin
        taken = '0;
        if (take) taken[pick] = 1'b1;
    end

    assign avail = |map;

    // Map update: clear the taken block, set the returned ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) map[i] <= (i >= NQ);
        end else begin
            map <= (map & ~taken) | give_back;
        end
    end
endmodule

// File: rtl/pool_wr_walker.sv
// Write position of one queue: two tail registers and a chunk offset.
// An offset above half selects the first register, otherwise the second.
// On a step at the last offset the second register takes the new block,
// and at the half point the first register catches up with it.
// Assumes new_blk is a valid free block whenever a step wraps.
module pool_wr_walker
    import mqp_pkg::*;
#(
    parameter int BLK_W    = 7,
    parameter int INIT_BLK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [BLK_W-1:0] new_blk,
    output logic [BLK_W-1:0] cur_blk,
    output logic [OFF_W-1:0] cur_off
);
    logic [BLK_W-1:0] tail_a, tail_b;
    logic [OFF_W-1:0] off;

    assign cur_blk = off[OFF_W-1] ? tail_a : tail_b;
    assign cur_off = off;

    // Advance the write position by one chunk per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_a <= BLK_W'(INIT_BLK);
            tail_b <= BLK_W'(INIT_BLK);
            off    <= '0;
        end else if (step) begin
            off <= off + 1'b1;
            if (off == HALF_LAST) tail_a <= tail_b;
            if (off == OFF_LAST)  tail_b <= new_blk;
        end
    end
endmodule

// File: rtl/pool_rd_walker.sv
// Read position of one queue: two head registers and a chunk offset.
// An offset above half selects the first register, otherwise the second.
// At the half point the previous block (first register) is released and
// the first register catches up. In the upper half, once the writer has
// left the current block, the link to the following block is fetched.
// Assumes a step happens only while the queue is not empty.
module pool_rd_walker
    import mqp_pkg::*;
#(
    parameter int BLK_W    = 7,
    parameter int INIT_BLK = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [BLK_W-1:0] a_next,
    input  logic [BLK_W-1:0] wr_blk,
    output logic [BLK_W-1:0] a_blk,
    output logic [BLK_W-1:0] cur_blk,
    output logic [OFF_W-1:0] cur_off,
    output logic             rel_en,
    output logic [BLK_W-1:0] rel_id
);
    logic [BLK_W-1:0] head_a, head_b;
    logic [OFF_W-1:0] off;

    assign a_blk   = head_a;
    assign cur_blk = off[OFF_W-1] ? head_a : head_b;
    assign cur_off = off;
    assign rel_en  = step && (off == HALF_LAST) && (head_a != head_b);
    assign rel_id  = head_a;

    // Advance the read position, release the old block, prefetch the link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_a <= BLK_W'(INIT_BLK);
            head_b <= BLK_W'(INIT_BLK);
            off    <= '0;
        end else begin
            if (step) off <= off + 1'b1;
            if (step && off == HALF_LAST) begin
                head_a <= head_b;
            end else if (off[OFF_W-1] && head_a == head_b && wr_blk != head_a) begin
                head_b <= a_next;
            end
        end
    end
endmodule

// File: rtl/mq_block_pool.sv
// Shared chunk store for NQ queues built from linked blocks.
// One producer writes in order; each queue is drained on its own port.
// Links between blocks sit in a next-block table indexed by block number.
// Assumes queue q owns block q at reset and that consumers only pop valid
// heads (pop_ready on an empty queue is ignored).
module mq_block_pool
    import mqp_pkg::*;
#(
    parameter int NQ   = 6,
    parameter int NBLK = 128,
    localparam int QID_W  = $clog2(NQ),
    localparam int BLK_W  = $clog2(NBLK),
    localparam int CNT_W  = $clog2(NBLK * CPB + 1),
    localparam int BCNT_W = $clog2(NBLK + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_valid,
    output logic                  push_ready,
    input  logic [QID_W-1:0]      push_qid,
    input  logic [CHUNK_W-1:0]    push_chunk,
    output logic [NQ-1:0]         pop_valid,
    input  logic [NQ-1:0]         pop_ready,
    output logic [NQ*CHUNK_W-1:0] pop_chunk,
    output logic [NQ*2-1:0]       pop_keep,
    output logic [NQ*CNT_W-1:0]   q_chunks,
    output logic [NQ*BCNT_W-1:0]  q_blocks
);
    localparam logic [QID_W-1:0] LASTQ = QID_W'(NQ - 1);

    logic [CHUNK_W-1:0] store   [NBLK*CPB];
    logic [BLK_W-1:0]   nxt_tbl [NBLK];

    logic [BLK_W-1:0] wr_blk [NQ];
    logic [BLK_W-1:0] rd_blk [NQ];
    logic [BLK_W-1:0] rd_a   [NQ];
    logic [BLK_W-1:0] rel_id [NQ];
    logic [OFF_W-1:0] wr_off [NQ];
    logic [OFF_W-1:0] rd_off [NQ];
    logic [NQ-1:0]    wr_step, pop_fire, rel_en;
    logic             avail, qid_ok, push_fire, alloc_take;
    logic [BLK_W-1:0] alloc_id;
    logic [QID_W-1:0] qsel;

    assign qid_ok     = push_qid <= LASTQ;
    assign qsel       = qid_ok ? push_qid : '0;
    assign push_ready = !qid_ok || !(wr_off[qsel] == OFF_LAST && !avail);
    assign push_fire  = push_valid && push_ready && qid_ok;
    assign alloc_take = push_fire && (wr_off[qsel] == OFF_LAST);

    pool_free_map #(.NBLK(NBLK), .NQ(NQ)) u_free (
        .clk(clk), .rst_n(rst_n), .take(alloc_take),
        .rel_en(rel_en), .rel_id(rel_id), .avail(avail), .pick(alloc_id)
    );

    // Store the pushed chunk and link a fresh block when the tail wraps.
    always_ff @(posedge clk) begin
        if (push_fire) store[{wr_blk[qsel], wr_off[qsel]}] <= push_chunk;
        if (alloc_take) nxt_tbl[wr_blk[qsel]] <= alloc_id;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [CNT_W-1:0]  chunk_cnt;
        logic [BCNT_W-1:0] blk_cnt;
        logic [CHUNK_W-1:0] head;

        assign wr_step[q] = push_fire && (qsel == QID_W'(q));

        pool_wr_walker #(.BLK_W(BLK_W), .INIT_BLK(q)) u_wr (
            .clk(clk), .rst_n(rst_n), .step(wr_step[q]), .new_blk(alloc_id),
            .cur_blk(wr_blk[q]), .cur_off(wr_off[q])
        );

        pool_rd_walker #(.BLK_W(BLK_W), .INIT_BLK(q)) u_rd (
            .clk(clk), .rst_n(rst_n), .step(pop_fire[q]),
            .a_next(nxt_tbl[rd_a[q]]), .wr_blk(wr_blk[q]), .a_blk(rd_a[q]),
            .cur_blk(rd_blk[q]), .cur_off(rd_off[q]),
            .rel_en(rel_en[q]), .rel_id(rel_id[q])
        );

        assign pop_valid[q] = (rd_blk[q] != wr_blk[q]) || (rd_off[q] != wr_off[q]);
        assign pop_fire[q]  = pop_valid[q] && pop_ready[q];
        assign head         = store[{rd_blk[q], rd_off[q]}];
        assign pop_chunk[q*CHUNK_W +: CHUNK_W] = head;
        assign pop_keep[q*2 +: 2] = pop_valid[q] ? slot_enables(head) : 2'b00;
        assign q_chunks[q*CNT_W +: CNT_W]    = chunk_cnt;
        assign q_blocks[q*BCNT_W +: BCNT_W]  = blk_cnt;

        // Chunk occupancy: up on push, down on pop.
        always_ff @(posedge clk) begin
            if (!rst_n) chunk_cnt <= '0;
            else if (wr_step[q] && !pop_fire[q]) chunk_cnt <= chunk_cnt + 1'b1;
            else if (!wr_step[q] && pop_fire[q]) chunk_cnt <= chunk_cnt - 1'b1;
        end

        // Block occupancy: up on tail allocation, down on head release.
        always_ff @(posedge clk) begin
            if (!rst_n) blk_cnt <= BCNT_W'(1);
            else if ((alloc_take && wr_step[q]) && !rel_en[q]) blk_cnt <= blk_cnt + 1'b1;
            else if (!(alloc_take && wr_step[q]) && rel_en[q]) blk_cnt <= blk_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mq_block_pool_chk.sv
// Property checker for the block pool, attached by bind. Observes ports only.
module mq_block_pool_chk #(
    parameter int NQ   = 6,
    parameter int NBLK = 128,
    localparam int CHUNK_W = 128,
    localparam int QID_W  = $clog2(NQ),
    localparam int CNT_W  = $clog2(NBLK * 8 + 1),
    localparam int BCNT_W = $clog2(NBLK + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  push_valid,
    input logic                  push_ready,
    input logic [QID_W-1:0]      push_qid,
    input logic [NQ-1:0]         pop_valid,
    input logic [NQ-1:0]         pop_ready,
    input logic [NQ*CHUNK_W-1:0] pop_chunk,
    input logic [NQ*CNT_W-1:0]   q_chunks,
    input logic [NQ*BCNT_W-1:0]  q_blocks
);
    localparam logic [QID_W-1:0] LASTQ = QID_W'(NQ - 1);

    p_bad_qid_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_qid > LASTQ) |-> push_ready);

    p_bad_qid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_qid > LASTQ && (pop_valid & pop_ready) == '0) |=> $stable(q_chunks));

    for (genvar q = 0; q < NQ; q++) begin : g_q
        localparam logic [QID_W-1:0] QV = QID_W'(q);

        p_empty_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pop_valid[q] == (q_chunks[q*CNT_W +: CNT_W] != '0));

        p_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (push_valid && push_ready && push_qid == QV && !(pop_valid[q] && pop_ready[q]))
            |=> q_chunks[q*CNT_W +: CNT_W] == CNT_W'($past(q_chunks[q*CNT_W +: CNT_W]) + 1'b1));

        p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (pop_valid[q] && !pop_ready[q]) |=> (pop_valid[q] && $stable(pop_chunk[q*CHUNK_W +: CHUNK_W])));

        p_blocks_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
            q_blocks[q*BCNT_W +: BCNT_W] != '0);

        p_pushpop_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (push_valid && push_ready && push_qid == QV && pop_valid[q] && pop_ready[q])
            |=> $stable(q_chunks[q*CNT_W +: CNT_W]));
    end
endmodule

bind mq_block_pool mq_block_pool_chk #(.NQ(NQ), .NBLK(NBLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .push_qid(push_qid), .pop_valid(pop_valid), .pop_ready(pop_ready),
    .pop_chunk(pop_chunk), .q_chunks(q_chunks), .q_blocks(q_blocks)
);

// File: tb/mq_block_pool_bench.sv
`timescale 1ns/1ps
module mq_block_pool_bench;
    localparam int NQ = 6;
    localparam int NBLK = 128;
    localparam int CW = 11;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic push_ready;
    logic [2:0] push_qid = '0;
    logic [127:0] push_chunk = '0;
    logic [NQ-1:0] pop_valid;
    logic [NQ-1:0] pop_ready = '0;
    logic [NQ*128-1:0] pop_chunk;
    logic [NQ*2-1:0] pop_keep;
    logic [NQ*CW-1:0] q_chunks;
    logic [NQ*BW-1:0] q_blocks;

    int n_tests = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mq_block_pool #(.NQ(NQ), .NBLK(NBLK)) u_mq_block_pool (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
        .push_qid(push_qid), .push_chunk(push_chunk), .pop_valid(pop_valid),
        .pop_ready(pop_ready), .pop_chunk(pop_chunk), .pop_keep(pop_keep),
        .q_chunks(q_chunks), .q_blocks(q_blocks)
    );

    function automatic logic [127:0] mk(input int q, input int n);
        return {8'(q), 24'(n), 32'hC0DE_0000 | 32'(n), 64'(n) * 64'h9E37_79B9_7F4A_7C15};
    endfunction

    function automatic int qc(input int q);
        return int'(q_chunks[q*CW +: CW]);
    endfunction

    function automatic int qb(input int q);
        return int'(q_blocks[q*BW +: BW]);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_push(input int q, input logic [127:0] d);
        push_valid = 1'b1; push_qid = 3'(q); push_chunk = d;
        @(negedge clk);
        while (!push_ready) @(negedge clk);
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic do_pop(input int q, input logic [127:0] exp, input string req);
        pop_ready[q] = 1'b1;
        @(negedge clk);
        chk(pop_valid[q] && pop_chunk[q*128 +: 128] == exp, req,
            longint'(pop_chunk[q*128 +: 32]), longint'(exp[31:0]));
        chk(pop_keep[q*2 +: 2] == exp[1:0], "R8", longint'(pop_keep[q*2 +: 2]), longint'(exp[1:0]));
        @(posedge clk); #1;
        pop_ready[q] = 1'b0;
    endtask

    task automatic t_reset();
        chk(pop_valid == '0, "R1 pop_valid", longint'(pop_valid), 0);
        chk(push_ready == 1'b1, "R1 push_ready", longint'(push_ready), 1);
        for (int q = 0; q < NQ; q++) begin
            chk(qc(q) == 0, "R1 q_chunks", qc(q), 0);
            chk(qb(q) == 1, "R1 q_blocks", qb(q), 1);
        end
    endtask

    // R7: fill queue 0 until the spare blocks are gone.
    task automatic t_exhaust();
        int n = 0;
        push_valid = 1'b1; push_qid = 3'd0;
        while (n < 2000) begin
            push_chunk = mk(0, n);
            @(negedge clk);
            if (!push_ready) break;
            @(posedge clk); #1;
            n++;
        end
        chk(n == 8 * (NBLK - NQ + 1) - 1, "R7 accepted before stall", n, 8 * (NBLK - NQ + 1) - 1);
        chk(qb(0) == NBLK - NQ + 1, "R7 q_blocks full", qb(0), NBLK - NQ + 1);
        push_qid = 3'd1;
        #1;
        chk(push_ready == 1'b1, "R7 other queue ready", longint'(push_ready), 1);
        push_valid = 1'b0;
        @(posedge clk); #1;
    endtask

    // R6/R7: release by pop and refused push in the same cycle.
    task automatic t_release_same_cycle();
        int last = 8 * (NBLK - NQ + 1) - 1;
        for (int i = 0; i < 11; i++) do_pop(0, mk(0, i), "R2 order q0");
        chk(qb(0) == NBLK - NQ + 1, "R6 before release", qb(0), NBLK - NQ + 1);
        pop_ready[0] = 1'b1;
        push_valid = 1'b1; push_qid = 3'd0; push_chunk = mk(0, last);
        @(negedge clk);
        chk(push_ready == 1'b0, "R7 same-cycle refused", longint'(push_ready), 0);
        chk(pop_chunk[127:0] == mk(0, 11), "R2 order q0", longint'(pop_chunk[31:0]), longint'(mk(0, 11)));
        @(posedge clk); #1;
        pop_ready[0] = 1'b0;
        @(negedge clk);
        chk(push_ready == 1'b1, "R7 ready after release", longint'(push_ready), 1);
        chk(qb(0) == NBLK - NQ, "R6 released", qb(0), NBLK - NQ);
        @(posedge clk); #1;
        push_valid = 1'b0;
        chk(qb(0) == NBLK - NQ + 1, "R5 reallocated", qb(0), NBLK - NQ + 1);
        chk(qc(0) == last - 12 + 1, "R4 q0 count", qc(0), last - 12 + 1);
        for (int i = 12; i <= last; i++) do_pop(0, mk(0, i), "R2 R5 drain q0");
        chk(pop_valid[0] == 1'b0 && qc(0) == 0, "R4 q0 empty", qc(0), 0);
    endtask

    task automatic t_basic();
        for (int i = 0; i < 3; i++) do_push(1, mk(1, i));
        chk(qc(1) == 3 && pop_valid[1], "R4 q1 count", qc(1), 3);
        for (int i = 0; i < 3; i++) do_pop(1, mk(1, i), "R2 q1");
        chk(!pop_valid[1] && pop_keep[3:2] == 2'b00, "R8 keep empty", longint'(pop_keep[3:2]), 0);
    endtask

    task automatic t_interleave();
        do_push(2, mk(2, 0)); do_push(3, mk(3, 0)); do_push(2, mk(2, 1)); do_push(4, mk(4, 0));
        do_pop(4, mk(4, 0), "R3 q4");
        chk(qc(2) == 2 && qc(3) == 1 && pop_chunk[2*128 +: 128] == mk(2, 0), "R3 others kept", qc(2), 2);
        do_pop(3, mk(3, 0), "R3 q3");
        chk(qc(2) == 2 && pop_valid[2], "R3 q2 untouched", qc(2), 2);
        do_pop(2, mk(2, 0), "R3 q2");
        do_pop(2, mk(2, 1), "R3 q2");
        chk((pop_valid & 6'b011100) == '0, "R4 all empty", longint'(pop_valid), 0);
    endtask

    task automatic t_chain();
        for (int i = 0; i < 7; i++) do_push(5, mk(5, i));
        chk(qb(5) == 1, "R5 before wrap", qb(5), 1);
        do_push(5, mk(5, 7));
        chk(qb(5) == 2, "R5 first wrap", qb(5), 2);
        for (int i = 8; i < 16; i++) do_push(5, mk(5, i));
        chk(qb(5) == 3, "R5 second wrap", qb(5), 3);
        for (int i = 0; i < 11; i++) do_pop(5, mk(5, i), "R5 order q5");
        chk(qb(5) == 3, "R6 held", qb(5), 3);
        do_pop(5, mk(5, 11), "R5 order q5");
        chk(qb(5) == 2, "R6 freed", qb(5), 2);
        for (int i = 12; i < 16; i++) do_pop(5, mk(5, i), "R5 order q5");
        chk(!pop_valid[5] && qb(5) == 2, "R6 end", qb(5), 2);
    endtask

    task automatic t_pushpop();
        do_push(5, mk(5, 16)); do_push(5, mk(5, 17));
        pop_ready[5] = 1'b1;
        push_valid = 1'b1; push_qid = 3'd5; push_chunk = mk(5, 18);
        @(negedge clk);
        chk(push_ready && pop_chunk[5*128 +: 128] == mk(5, 16), "R10 head", longint'(pop_chunk[5*128 +: 32]), longint'(mk(5, 16)));
        @(posedge clk); #1;
        pop_ready[5] = 1'b0; push_valid = 1'b0;
        chk(qc(5) == 2, "R10 count", qc(5), 2);
        do_pop(5, mk(5, 17), "R10 order");
        do_pop(5, mk(5, 18), "R10 order");
    endtask

    task automatic t_bad_qid();
        push_valid = 1'b1; push_qid = 3'd6; push_chunk = mk(6, 0);
        @(negedge clk);
        chk(push_ready == 1'b1, "R9 ready qid6", longint'(push_ready), 1);
        @(posedge clk); #1;
        push_qid = 3'd7;
        @(negedge clk);
        chk(push_ready == 1'b1, "R9 ready qid7", longint'(push_ready), 1);
        @(posedge clk); #1;
        push_valid = 1'b0;
        chk(pop_valid == '0, "R9 nothing stored", longint'(pop_valid), 0);
        for (int q = 0; q < NQ; q++) chk(qc(q) == 0, "R9 counts", qc(q), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_exhaust();
        t_release_same_cycle();
        t_basic();
        t_interleave();
        t_chain();
        t_pushpop();
        t_bad_qid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule